// File: doc/BRIEF.md
# Reorder Buffer with Atomic Instruction Retirement

This block holds in-flight micro-operations between dispatch and commit. A front end writes one whole instruction per cycle, made of one to three micro-operations, each naming the architectural register it will write. Execution units later report each micro-operation as finished by its slot number, in any order, with a result value and a flag that says whether a branch went the wrong way. The block commits results to the register file strictly in program order. Up to three micro-operations commit per cycle.

Commitment is all-or-nothing per instruction. An instruction leaves only when every one of its micro-operations has finished and every older instruction has already left. If its micro-operations do not all fit in the commit lanes left in the current cycle, the whole instruction waits for the next cycle. A finished micro-operation that reports a wrong branch discards every younger slot at once. It then becomes the final micro-operation of its instruction and commits normally. A redirect pulse tells the front end where the surviving stream ends.

Top module: `rob_inorder_retire`

## Requirements
- R1: After synchronous reset the buffer is empty. No commit lane and no redirect is active, `alloc_idx` is 0, and `alloc_ready` is high for any count from 1 to 3.
- R2: The buffer holds DEPTH (40) slots. An instruction of `alloc_cnt` micro-operations is accepted only when at least `alloc_cnt` slots are free, and `alloc_ready` shows that decision. A `alloc_cnt` of 0 allocates nothing.
- R3: Micro-operations of an accepted instruction take consecutive slots starting at `alloc_idx`, which wraps from 39 to 0. Lane u of `alloc_dest` (bits u*5 upward) belongs to the slot `alloc_idx`+u.
- R4: Completions may arrive in any order. A completion is ignored if its slot is out of range, not occupied, or already complete.
- R5: Committed destinations and values appear in allocation order: lane 0 carries the oldest, and across cycles the sequence matches program order.
- R6: At most 3 micro-operations commit per cycle, and the active lanes of `ret_valid` always form a prefix starting at lane 0.
- R7: An instruction commits only when all its micro-operations are complete, and all of them commit in the same cycle. It is never split across cycles, even when lanes remain free.
- R8: A group that becomes complete at the head commits on the clock edge after the edge that recorded its last completion.
- R9: An accepted completion with the mispredict flag discards every younger slot. That micro-operation ends its instruction and still commits once it reaches the head, and the next allocation starts at the slot just after it.
- R10: One cycle after an accepted mispredict completion, `redirect_valid` pulses for one cycle with `redirect_idx` equal to that slot.
- R11: In a cycle that accepts a mispredict completion, `alloc_ready` is low and no allocation occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | An instruction is offered for allocation |
| alloc_cnt | input | 2 | Number of micro-operations in the offered instruction (1..3) |
| alloc_dest | input | 15 | Destination register per micro-operation, 5 bits each, lane 0 lowest |
| alloc_ready | output | 1 | Offered instruction is accepted this cycle |
| alloc_idx | output | 6 | Slot given to the first micro-operation |
| cmp_valid | input | 1 | A completion report is present |
| cmp_idx | input | 6 | Slot being completed |
| cmp_data | input | 32 | Result value |
| cmp_mispred | input | 1 | The completed micro-operation resolved a wrong-path branch |
| ret_valid | output | 3 | Commit lane enables, prefix from lane 0 |
| ret_dest | output | 15 | Destination register per commit lane |
| ret_data | output | 96 | Result value per commit lane |
| redirect_valid | output | 1 | One-cycle pulse after a flush |
| redirect_idx | output | 6 | Slot of the mispredicted micro-operation |

## Verification
On every cycle the assertions check the lane prefix shape, the occupancy bound, that allocation is blocked in a flush cycle, the redirect pulse and its slot, and that the allocation pointer lands just after the flushed slot. Program order of commits, whole-instruction grouping, the refusal to split across cycles, the commit latency and the ignoring of stale completions show only in the bench's scenarios. The bench's queue model predicts every lane on every clock while completions arrive in reverse and random order and mispredicts occur.

// File: rtl/rob_pkg.sv
package rob_pkg;

  // Ring arithmetic on slot numbers; b and the distance are below depth.
  function automatic int ring_add(int a, int b, int depth);
    int s;
    s = a + b;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  function automatic int ring_dist(int from, int to, int depth);
    return (to >= from) ? (to - from) : (to + depth - from);
  endfunction

endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs import rob_pkg::*; #(
  parameter int DEPTH    = 40,
  parameter int MAX_UOPS = 3,
  parameter int RET_W    = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int OCC_W   = $clog2(DEPTH + 1),
  localparam int UCNT_W  = $clog2(MAX_UOPS + 1),
  localparam int RCNT_W  = $clog2(RET_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_fire,
  input  logic [UCNT_W-1:0] alloc_cnt,
  input  logic [RCNT_W-1:0] nret,
  input  logic              flush,
  input  logic [IDX_W-1:0]  flush_idx,
  output logic [IDX_W-1:0]  head,
  output logic [IDX_W-1:0]  tail,
  output logic [OCC_W-1:0]  count
);

  logic [IDX_W-1:0] head_nx;

  always_comb head_nx = IDX_W'(ring_add(int'(head), int'(nret), DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      head <= head_nx;
      if (flush) begin
        // Keep everything up to and including the wrong-path branch.
        tail  <= IDX_W'(ring_add(int'(flush_idx), 1, DEPTH));
        count <= OCC_W'(ring_dist(int'(head_nx), int'(flush_idx), DEPTH) + 1);
      end else begin
        if (alloc_fire) tail <= IDX_W'(ring_add(int'(tail), int'(alloc_cnt), DEPTH));
        count <= OCC_W'(int'(count) - int'(nret) + (alloc_fire ? int'(alloc_cnt) : 0));
      end
    end
  end

endmodule

// File: rtl/rob_store.sv
module rob_store import rob_pkg::*; #(
  parameter int DEPTH    = 40,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  parameter int MAX_UOPS = 3,
  parameter int RET_W    = 3,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int UCNT_W  = $clog2(MAX_UOPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_fire,
  input  logic [IDX_W-1:0]          alloc_base,
  input  logic [UCNT_W-1:0]         alloc_cnt,
  input  logic [MAX_UOPS*REG_W-1:0] alloc_dest,
  input  logic                      cmp_we,
  input  logic [IDX_W-1:0]          cmp_idx,
  input  logic [DATA_W-1:0]         cmp_data,
  input  logic                      cmp_mark_last,
  input  logic [IDX_W-1:0]          head,
  output logic                      cmp_seen_done,
  output logic [RET_W-1:0]          win_done,
  output logic [RET_W-1:0]          win_last,
  output logic [RET_W*REG_W-1:0]    win_dest,
  output logic [RET_W*DATA_W-1:0]   win_data
);

  logic [DEPTH-1:0]  done_q;
  logic [DEPTH-1:0]  last_q;
  logic [REG_W-1:0]  dest_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  logic [IDX_W-1:0]    wr_addr [MAX_UOPS];
  logic [MAX_UOPS-1:0] wr_en;

  always_comb begin
    for (int u = 0; u < MAX_UOPS; u++) begin
      wr_addr[u] = IDX_W'(ring_add(int'(alloc_base), u, DEPTH));
      wr_en[u]   = alloc_fire && (u < int'(alloc_cnt));
    end
  end

  // Status flags: reset, written by allocation and completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= '0;
      last_q <= '0;
    end else begin
      for (int u = 0; u < MAX_UOPS; u++) begin
        if (wr_en[u]) begin
          done_q[wr_addr[u]] <= 1'b0;
          last_q[wr_addr[u]] <= (u == int'(alloc_cnt) - 1);
        end
      end
      if (cmp_we) begin
        done_q[cmp_idx] <= 1'b1;
        if (cmp_mark_last) last_q[cmp_idx] <= 1'b1;
      end
    end
  end

  // Payload arrays: no reset, one write port each.
  always_ff @(posedge clk) begin
    for (int u = 0; u < MAX_UOPS; u++) begin
      if (wr_en[u]) dest_mem[wr_addr[u]] <= alloc_dest[u*REG_W +: REG_W];
    end
    if (cmp_we) data_mem[cmp_idx] <= cmp_data;
  end

  always_comb cmp_seen_done = (int'(cmp_idx) < DEPTH) ? done_q[cmp_idx] : 1'b1;

  for (genvar k = 0; k < RET_W; k++) begin : g_win
    logic [IDX_W-1:0] rd_addr;
    assign rd_addr                        = IDX_W'(ring_add(int'(head), k, DEPTH));
    assign win_done[k]                    = done_q[rd_addr];
    assign win_last[k]                    = last_q[rd_addr];
    assign win_dest[k*REG_W +: REG_W]     = dest_mem[rd_addr];
    assign win_data[k*DATA_W +: DATA_W]   = data_mem[rd_addr];
  end

endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
  parameter int DEPTH  = 40,
  parameter int RET_W  = 3,
  localparam int OCC_W  = $clog2(DEPTH + 1),
  localparam int RCNT_W = $clog2(RET_W + 1)
) (
  input  logic [OCC_W-1:0]  count,
  input  logic [RET_W-1:0]  win_done,
  input  logic [RET_W-1:0]  win_last,
  output logic [RCNT_W-1:0] nret
);

  logic open_run;

  // Walk the head window; commit up to the last closed instruction in an
  // unbroken run of finished slots.
  always_comb begin
    nret     = '0;
    open_run = 1'b1;
    for (int k = 0; k < RET_W; k++) begin
      if (open_run && (k < int'(count)) && win_done[k]) begin
        if (win_last[k]) nret = RCNT_W'(k + 1);
      end else begin
        open_run = 1'b0;
      end
    end
  end

endmodule

// File: rtl/rob_inorder_retire.sv
module rob_inorder_retire import rob_pkg::*; #(
  parameter int DEPTH    = 40,
  parameter int RET_W    = 3,
  parameter int MAX_UOPS = 3,
  parameter int REG_W    = 5,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(DEPTH),
  localparam int OCC_W   = $clog2(DEPTH + 1),
  localparam int UCNT_W  = $clog2(MAX_UOPS + 1),
  localparam int RCNT_W  = $clog2(RET_W + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      alloc_valid,
  input  logic [UCNT_W-1:0]         alloc_cnt,
  input  logic [MAX_UOPS*REG_W-1:0] alloc_dest,
  output logic                      alloc_ready,
  output logic [IDX_W-1:0]          alloc_idx,
  input  logic                      cmp_valid,
  input  logic [IDX_W-1:0]          cmp_idx,
  input  logic [DATA_W-1:0]         cmp_data,
  input  logic                      cmp_mispred,
  output logic [RET_W-1:0]          ret_valid,
  output logic [RET_W*REG_W-1:0]    ret_dest,
  output logic [RET_W*DATA_W-1:0]   ret_data,
  output logic                      redirect_valid,
  output logic [IDX_W-1:0]          redirect_idx
);

  logic [IDX_W-1:0]        head, tail;
  logic [OCC_W-1:0]        count;
  logic [RCNT_W-1:0]       nret;
  logic                    cmp_ok, cmp_seen_done, flush, alloc_fire;
  logic [RET_W-1:0]        win_done, win_last;
  logic [RET_W*REG_W-1:0]  win_dest;
  logic [RET_W*DATA_W-1:0] win_data;

  always_comb begin
    cmp_ok = cmp_valid && (int'(cmp_idx) < DEPTH) && !cmp_seen_done &&
             (ring_dist(int'(head), int'(cmp_idx), DEPTH) < int'(count));
    flush       = cmp_ok && cmp_mispred;
    alloc_ready = ((DEPTH - int'(count)) >= int'(alloc_cnt)) && !flush;
    alloc_fire  = alloc_valid && alloc_ready && (alloc_cnt != '0) &&
                  (int'(alloc_cnt) <= MAX_UOPS);
    alloc_idx   = tail;
  end

  rob_ptrs #(.DEPTH(DEPTH), .MAX_UOPS(MAX_UOPS), .RET_W(RET_W)) u_ptrs (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_cnt(alloc_cnt),
    .nret(nret), .flush(flush), .flush_idx(cmp_idx),
    .head(head), .tail(tail), .count(count)
  );

  rob_store #(.DEPTH(DEPTH), .REG_W(REG_W), .DATA_W(DATA_W),
              .MAX_UOPS(MAX_UOPS), .RET_W(RET_W)) u_store (
    .clk(clk), .rst(rst), .alloc_fire(alloc_fire), .alloc_base(tail),
    .alloc_cnt(alloc_cnt), .alloc_dest(alloc_dest), .cmp_we(cmp_ok),
    .cmp_idx(cmp_idx), .cmp_data(cmp_data), .cmp_mark_last(cmp_mispred),
    .head(head), .cmp_seen_done(cmp_seen_done), .win_done(win_done),
    .win_last(win_last), .win_dest(win_dest), .win_data(win_data)
  );

  rob_retire_pick #(.DEPTH(DEPTH), .RET_W(RET_W)) u_pick (
    .count(count), .win_done(win_done), .win_last(win_last), .nret(nret)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid      <= '0;
      ret_dest       <= '0;
      ret_data       <= '0;
      redirect_valid <= 1'b0;
      redirect_idx   <= '0;
    end else begin
      for (int k = 0; k < RET_W; k++) ret_valid[k] <= (k < int'(nret));
      ret_dest       <= win_dest;
      ret_data       <= win_data;
      redirect_valid <= flush;
      if (flush) redirect_idx <= cmp_idx;
    end
  end

endmodule

// File: rtl/rob_inorder_retire_chk.sv
module rob_inorder_retire_chk #(
  parameter int DEPTH = 40,
  parameter int RET_W = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cmp_ok,
  input logic             cmp_mispred,
  input logic [IDX_W-1:0] cmp_idx,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic [RET_W-1:0] ret_valid,
  input logic             redirect_valid,
  input logic [IDX_W-1:0] redirect_idx,
  input logic [OCC_W-1:0] count
);

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ret_valid == '0 && !redirect_valid));

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    int'(count) <= DEPTH);

  p_lane_prefix_r6: assert property (@(posedge clk) disable iff (rst)
    ((({1'b0, ret_valid}) + 1'b1) & {1'b0, ret_valid}) == '0);

  p_tail_after_flush_r9: assert property (@(posedge clk) disable iff (rst)
    redirect_valid |->
      int'(alloc_idx) == ((int'(redirect_idx) == DEPTH - 1) ? 0 : int'(redirect_idx) + 1));

  p_redirect_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (cmp_ok && cmp_mispred) |=> (redirect_valid && redirect_idx == $past(cmp_idx)));

  p_redirect_cause_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(redirect_valid) |-> $past(cmp_ok && cmp_mispred));

  p_flush_blocks_alloc_r11: assert property (@(posedge clk) disable iff (rst)
    (cmp_ok && cmp_mispred) |-> !alloc_ready);

endmodule

bind rob_inorder_retire rob_inorder_retire_chk #(.DEPTH(DEPTH), .RET_W(RET_W)) u_chk (
  .clk(clk), .rst(rst), .cmp_ok(cmp_ok), .cmp_mispred(cmp_mispred),
  .cmp_idx(cmp_idx), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
  .ret_valid(ret_valid), .redirect_valid(redirect_valid),
  .redirect_idx(redirect_idx), .count(count)
);

// File: tb/tb_rob_inorder_retire.sv
module tb_rob_inorder_retire;

  localparam int DEPTH = 40, RET_W = 3, MAX_UOPS = 3, REG_W = 5, DATA_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                      rst;
  logic                      alloc_valid;
  logic [1:0]                alloc_cnt;
  logic [MAX_UOPS*REG_W-1:0] alloc_dest;
  logic                      alloc_ready;
  logic [5:0]                alloc_idx;
  logic                      cmp_valid;
  logic [5:0]                cmp_idx;
  logic [DATA_W-1:0]         cmp_data;
  logic                      cmp_mispred;
  logic [RET_W-1:0]          ret_valid;
  logic [RET_W*REG_W-1:0]    ret_dest;
  logic [RET_W*DATA_W-1:0]   ret_data;
  logic                      redirect_valid;
  logic [5:0]                redirect_idx;

  rob_inorder_retire dut (
    .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_cnt(alloc_cnt),
    .alloc_dest(alloc_dest), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .cmp_valid(cmp_valid), .cmp_idx(cmp_idx), .cmp_data(cmp_data),
    .cmp_mispred(cmp_mispred), .ret_valid(ret_valid), .ret_dest(ret_dest),
    .ret_data(ret_data), .redirect_valid(redirect_valid), .redirect_idx(redirect_idx)
  );

  typedef struct {
    int          idx;
    int          dest;
    bit          done;
    bit          last;
    int unsigned data;
  } ent_t;

  ent_t        q[$];
  int          m_tail;
  bit [2:0]    e_rv;
  int          e_rdest [RET_W];
  int unsigned e_rdata [RET_W];
  bit          e_redir;
  int          e_redir_idx;
  int          n_vec, n_bad;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // One clock: drive at the falling edge, compare, advance the model.
  task automatic step(bit av, int acnt, bit cv, int cidx, bit cmis);
    int  pos, n;
    bit  acc, flush, m_ready, fire;
    alloc_valid = av;
    alloc_cnt   = 2'(acnt);
    alloc_dest  = 15'($urandom);
    cmp_valid   = cv;
    cmp_idx     = 6'(cidx);
    cmp_data    = $urandom;
    cmp_mispred = cmis;
    #1;
    pos = -1;
    for (int i = 0; i < q.size(); i++)
      if (cv && q[i].idx == cidx && !q[i].done) pos = i;
    acc     = (pos >= 0);
    flush   = acc && cmis;
    m_ready = ((DEPTH - q.size()) >= acnt) && !flush;
    chk(alloc_ready == m_ready, flush ? "R11" : "R2", "alloc_ready", alloc_ready, m_ready);
    chk(int'(alloc_idx) == m_tail, "R3", "alloc_idx", alloc_idx, m_tail);
    chk(ret_valid == e_rv, "R7", "ret_valid", ret_valid, e_rv);
    for (int k = 0; k < RET_W; k++) begin
      if (e_rv[k]) begin
        chk(int'(ret_dest[k*REG_W +: REG_W]) == e_rdest[k], "R5", "ret_dest",
            ret_dest[k*REG_W +: REG_W], e_rdest[k]);
        chk(ret_data[k*DATA_W +: DATA_W] == e_rdata[k], "R5", "ret_data",
            ret_data[k*DATA_W +: DATA_W], e_rdata[k]);
      end
    end
    chk(redirect_valid == e_redir, "R10", "redirect_valid", redirect_valid, e_redir);
    if (e_redir)
      chk(int'(redirect_idx) == e_redir_idx, "R10", "redirect_idx", redirect_idx, e_redir_idx);

    // Model: commit run from the head (R6, R7, R8), then completion, then allocation.
    n = 0;
    for (int k = 0; k < RET_W && k < q.size(); k++) begin
      if (!q[k].done) break;
      if (q[k].last) n = k + 1;
    end
    e_rv = 3'((1 << n) - 1);
    for (int k = 0; k < n; k++) begin
      e_rdest[k] = q[k].dest;
      e_rdata[k] = q[k].data;
    end
    fire = av && m_ready && acnt >= 1 && acnt <= MAX_UOPS;
    if (acc) begin
      q[pos].done = 1'b1;
      q[pos].data = cmp_data;
      if (cmis) begin
        q[pos].last = 1'b1;
        while (q.size() > pos + 1) void'(q.pop_back());
        m_tail = (cidx + 1) % DEPTH;
      end
    end
    e_redir     = flush;
    e_redir_idx = cidx;
    for (int k = 0; k < n; k++) void'(q.pop_front());
    if (fire) begin
      for (int u = 0; u < acnt; u++) begin
        ent_t e;
        e.idx  = m_tail;
        e.dest = int'(alloc_dest[u*REG_W +: REG_W]);
        e.done = 1'b0;
        e.last = (u == acnt - 1);
        e.data = 0;
        q.push_back(e);
        m_tail = (m_tail + 1) % DEPTH;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic int pick_undone(bit youngest);
    int cand[$];
    for (int i = 0; i < q.size(); i++) if (!q[i].done) cand.push_back(q[i].idx);
    if (cand.size() == 0) return -1;
    if (youngest) return cand[cand.size() - 1];
    return cand[$urandom_range(cand.size() - 1)];
  endfunction

  task automatic drain();
    int c;
    c = pick_undone(1'b0);
    while (c >= 0) begin
      step(1'b0, 1, 1'b1, c, 1'b0);
      c = pick_undone(1'b0);
    end
    repeat (4) step(1'b0, 1, 1'b0, 0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 200000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int c;
    n_vec = 0; n_bad = 0; m_tail = 0;
    e_rv = '0; e_redir = 1'b0; e_redir_idx = 0;
    rst = 1'b1;
    alloc_valid = 1'b0; alloc_cnt = 2'd1; alloc_dest = '0;
    cmp_valid = 1'b0; cmp_idx = '0; cmp_data = '0; cmp_mispred = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, compared on the first step with an empty model.
    alloc_cnt = 2'd3;
    #1;
    chk(ret_valid == '0, "R1", "ret_valid", ret_valid, 0);
    chk(!redirect_valid, "R1", "redirect_valid", redirect_valid, 0);
    chk(alloc_idx == '0, "R1", "alloc_idx", alloc_idx, 0);
    chk(alloc_ready, "R1", "alloc_ready", alloc_ready, 1);

    // R2: fill 39 slots with triples, then stalls, then the final single slot.
    for (int i = 0; i < 14; i++) step(1'b1, 3, 1'b0, 0, 1'b0);
    step(1'b1, 2, 1'b0, 0, 1'b0);
    step(1'b1, 1, 1'b0, 0, 1'b0);
    step(1'b1, 1, 1'b0, 0, 1'b0);
    step(1'b1, 0, 1'b0, 0, 1'b0);  // R2: zero count allocates nothing

    // R4: out-of-range slot is ignored.
    step(1'b0, 1, 1'b1, 45, 1'b0);
    // R7, R8: complete in reverse program order; nothing commits until the head group closes.
    c = pick_undone(1'b1);
    while (c >= 0) begin
      step(1'b0, 1, 1'b1, c, 1'b0);
      step(1'b0, 1, 1'b1, c, 1'b0);  // R4: repeat completion is ignored
      c = pick_undone(1'b1);
    end
    repeat (20) step(1'b0, 1, 1'b0, 0, 1'b0);

    // R3, R7: single-uop then triple; triple may not split across cycles.
    step(1'b1, 1, 1'b0, 0, 1'b0);
    step(1'b1, 3, 1'b0, 0, 1'b0);
    step(1'b1, 2, 1'b0, 0, 1'b0);
    drain();

    // R9, R10, R11: mispredict on the middle uop of a triple with younger work behind it.
    step(1'b1, 3, 1'b0, 0, 1'b0);
    step(1'b1, 3, 1'b0, 0, 1'b0);
    step(1'b1, 3, 1'b1, q[1].idx, 1'b1);
    step(1'b1, 2, 1'b0, 0, 1'b0);
    // R4: completion to a slot discarded by the flush is ignored.
    step(1'b0, 1, 1'b1, (m_tail + 5) % DEPTH, 1'b0);
    drain();

    // R5, R6, R9: long random run with completions in random order.
    for (int i = 0; i < 4000; i++) begin
      bit av, cv, cm;
      int ac, ci;
      av = ($urandom % 3) != 0;
      ac = 1 + ($urandom % 3);
      cv = ($urandom % 4) != 0;
      cm = ($urandom % 25) == 0;
      ci = pick_undone(1'b0);
      if (ci < 0 || ($urandom % 20) == 0) ci = $urandom % 64;
      step(av, ac, cv, ci, cm);
    end
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule